// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer/counter channels, each kept as a pair of 8-bit count registers (a low byte and a high byte). Every channel counts either a machine-cycle tick strobe or falling edges on its own external count pin. Counting can be held off by an external gate pin. A shared configuration register chooses one of four counting modes per channel: 13-bit with a 5-bit prescaler, full 16-bit, 8-bit with auto-reload from the high byte, and a split mode.

A second register holds the run enables and the two overflow flags. The flags go to an interrupt controller, which clears them through an acknowledge input. Software can also write them. In split mode channel 0 turns into two independent 8-bit counters, and its high half takes over channel 1's run enable and flag. Channel 1 keeps counting so that its overflow pulse can still drive a serial baud source.

Register map (addr): 0 config, 1 run/flag, 2 channel 0 low, 3 channel 0 high, 4 channel 1 low, 5 channel 1 high; addresses 6 and 7 read zero. Config bits: [1:0] mode of channel 0, [2] external-source select of channel 0, [3] gate enable of channel 0, [5:4] mode of channel 1, [6] external select of channel 1, [7] gate enable of channel 1. Mode codes: 00 = 13-bit, 01 = 16-bit, 10 = 8-bit reload, 11 = split (channel 0) or halt (channel 1). Run/flag bits: [0] run 0, [1] run 1, [2] flag 0, [3] flag 1, [7:4] read zero.

Top module: `dual_timer`

## Requirements
- R1: After reset, every register in the map reads zero and both overflow flag outputs are low.
- R2: A channel advances only while its run bit is 1 and its gate-enable bit is 0 or its gate pin is high. With run 0 (outside split mode) its count registers stay unchanged.
- R3: With the external select bit at 0, a channel counts one per tick strobe cycle. With the select bit at 1, the pin passes through two synchroniser flops and is sampled on tick cycles. Exactly one count is taken for each 1-to-0 change seen between consecutive samples, and a pin held steady at either level adds nothing.
- R4: In mode 00 the count is {high, low[4:0]}. low[7:5] never change through counting. Rolling from 0x1FFF to 0 sets the channel flag, and a carry out of low[4:0] increments the high byte.
- R5: In mode 01 the count is the 16-bit value {high, low}. Rolling from 0xFFFF to 0 sets the channel flag.
- R6: In mode 10, when low is 0xFF and a count arrives, low takes the high byte's value, the high byte is unchanged, and the flag is set. Otherwise low increments.
- R7: Channel 1 in mode 11 holds its count and raises no flag or pulse.
- R8: With channel 0 in mode 11, its low byte counts as an 8-bit counter under channel 0's run, gate and select bits and sets flag 0 on overflow. Its high byte counts ticks only while run 1 is set, ignoring both gate settings, and sets flag 1 on 0xFF-to-0. Channel 1 then counts without needing run 1 and never sets flag 1.
- R9: Writing a 1 to a run bit leaves the count registers as they were. A flag is cleared by writing 0 to it or by its acknowledge input. An overflow in the same cycle as an acknowledge leaves the flag set.
- R10: A software write to a count register wins over a count or reload of that register in the same cycle.
- R11: baud_pulse goes high for one cycle, in the cycle after each channel 1 overflow or reload, including during split mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| tick | input | 1 | Machine-cycle strobe, one clock wide |
| cnt_pin | input | 2 | External count inputs, bit n for channel n |
| gate_pin | input | 2 | External gate inputs, bit n for channel n |
| ack | input | 2 | Flag acknowledge from interrupt vectoring |
| ovf_flag | output | 2 | Overflow flags of channel 0 and 1 |
| baud_pulse | output | 1 | One-cycle pulse on channel 1 overflow |

## Verification
A wrong mode decode or a misrouted carry shows up in the count registers after the first tick that crosses the affected bit, so a bench that preloads values one count below each rollover sees it at once. A flag routed to the wrong channel in split mode appears on ovf_flag one cycle after that overflow. A broken edge detector shows as a count that is too high or too low by the first tick after the synchroniser delay. Write priority errors show as a read value one above the written one on the very next read.

// File: rtl/dual_timer.sv
module dual_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tick,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  input  logic [1:0] ack,
  output logic [1:0] ovf_flag,
  output logic       baud_pulse
);

  logic [7:0] cfg_q, lo0, hi0, lo1, hi1;
  logic [1:0] run_q, flg_q;
  logic [1:0] sy1, sy2, smp;

  function automatic logic [16:0] step(input logic [1:0] m, input logic [7:0] h, input logic [7:0] l);
    logic [4:0] l5;
    logic       c;
    case (m)
      2'b00: begin
        l5 = l[4:0] + 5'd1;
        c  = &l[4:0];
        return {c & (&h), h + {7'd0, c}, l[7:5], l5};
      end
      2'b01:   return {1'b0, h, l} + 17'd1;
      2'b10:   return (&l) ? {1'b1, h, h} : {1'b0, h, l + 8'd1};
      default: return {&l, h, l + 8'd1};
    endcase
  endfunction

  wire [1:0] m0 = cfg_q[1:0];
  wire [1:0] m1 = cfg_q[5:4];
  wire       split = (m0 == 2'b11);

  wire [1:0] ev   = {2{tick}} & smp & ~sy2;
  wire       src0 = cfg_q[2] ? ev[0] : tick;
  wire       src1 = cfg_q[6] ? ev[1] : tick;
  wire       en0  = run_q[0] & (~cfg_q[3] | gate_pin[0]) & src0;
  wire       en1  = (split | run_q[1]) & (~cfg_q[7] | gate_pin[1]) & src1 & (m1 != 2'b11);
  wire       enh  = split & run_q[1] & tick;

  wire [16:0] s0 = step(m0, hi0, lo0);
  wire [16:0] s1 = step(m1, hi1, lo1);

  wire ov0  = en0 & s0[16];
  wire ov1  = en1 & s1[16];
  wire ovh  = enh & (&hi0);
  wire [1:0] setf = {split ? ovh : ov1, ov0};

  wire [7:0] n_hi0 = split ? (enh ? hi0 + 8'd1 : hi0) : (en0 ? s0[15:8] : hi0);

  wire w_cfg = wr_en & (addr == 3'd0);
  wire w_run = wr_en & (addr == 3'd1);
  wire w_lo0 = wr_en & (addr == 3'd2);
  wire w_hi0 = wr_en & (addr == 3'd3);
  wire w_lo1 = wr_en & (addr == 3'd4);
  wire w_hi1 = wr_en & (addr == 3'd5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; run_q <= '0; flg_q <= '0;
      lo0 <= '0; hi0 <= '0; lo1 <= '0; hi1 <= '0;
      sy1 <= '0; sy2 <= '0; smp <= '0;
      baud_pulse <= 1'b0;
    end else begin
      sy1 <= cnt_pin;
      sy2 <= sy1;
      if (tick) smp <= sy2;
      if (w_cfg) cfg_q <= wdata;
      if (w_run) begin
        run_q <= wdata[1:0];
        flg_q <= wdata[3:2];
      end else begin
        flg_q <= (flg_q & ~ack) | setf;
      end
      lo0 <= w_lo0 ? wdata : (en0 ? s0[7:0] : lo0);
      hi0 <= w_hi0 ? wdata : n_hi0;
      lo1 <= w_lo1 ? wdata : (en1 ? s1[7:0] : lo1);
      hi1 <= w_hi1 ? wdata : (en1 ? s1[15:8] : hi1);
      baud_pulse <= ov1;
    end
  end

  assign ovf_flag = flg_q;

  always_comb begin
    case (addr)
      3'd0:    rdata = cfg_q;
      3'd1:    rdata = {4'd0, flg_q, run_q};
      3'd2:    rdata = lo0;
      3'd3:    rdata = hi0;
      3'd4:    rdata = lo1;
      3'd5:    rdata = hi1;
      default: rdata = 8'd0;
    endcase
  end

  // R2: stopped channel 0 keeps its count
  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[0] && !split && !w_lo0 && !w_hi0) |=> ($stable(lo0) && $stable(hi0)));

  // R4: prescaler top bits untouched in 13-bit mode
  a_r4_upper_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (m0 == 2'b00 && !w_lo0) |=> (lo0[7:5] == $past(lo0[7:5])));

  // R6: reload copies the high byte and raises the flag
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (m0 == 2'b10 && en0 && lo0 == 8'hFF && !w_lo0 && !w_hi0 && !w_run)
      |=> (lo0 == $past(hi0) && $stable(hi0) && flg_q[0]));

  // R7: halted channel 1 does not move
  a_r7_ch1_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (m1 == 2'b11 && !w_lo1 && !w_hi1) |=> ($stable(lo1) && $stable(hi1)));

  // R11: outside split mode the pulse comes with flag 1
  a_r11_pulse_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_pulse && !$past(split) && !$past(w_run)) |-> flg_q[1]);

endmodule

// File: tb/tb_dual_timer.sv
module tb_dual_timer;
  logic clk = 0, rst_n = 0, wr_en = 0, tick = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [1:0] cnt_pin = 2'b11, gate_pin = 2'b00, ack = 2'b00;
  logic [7:0] rdata;
  logic [1:0] ovf_flag;
  logic baud_pulse;
  int n_run = 0, n_fail = 0;

  dual_timer dut (.clk, .rst_n, .wr_en, .addr, .wdata, .rdata, .tick,
                  .cnt_pin, .gate_pin, .ack, .ovf_flag, .baud_pulse);

  always #4 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk); rst_n = 0; wr_en = 0; tick = 0; ack = 0;
    cnt_pin = 2'b11; gate_pin = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(string tag, input logic [2:0] a, input int exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic t_reset();
    reset_dut();
    for (int a = 0; a < 8; a++) rd("R1 reset reg", 3'(a), 0);
    chk("R1 reset flags", ovf_flag, 0);
  endtask

  task automatic t_gate();
    reset_dut();
    wr(0, 8'h09);
    wr(1, 8'h01);
    gate_pin[0] = 0;
    tk(5);
    rd("R2 gate low blocks", 2, 0);
    gate_pin[0] = 1;
    tk(5);
    rd("R2 gate high counts", 2, 5);
    wr(1, 8'h00);
    tk(3);
    rd("R2 run off holds", 2, 5);
    wr(1, 8'h01);
    rd("R9 run set keeps count", 2, 5);
  endtask

  task automatic t_ext();
    reset_dut();
    wr(0, 8'h50);
    wr(1, 8'h02);
    tk(3);
    rd("R3 steady high no count", 4, 0);
    for (int e = 1; e <= 3; e++) begin
      @(negedge clk); cnt_pin[1] = 0;
      repeat (3) @(negedge clk);
      tk(3);
      rd("R3 one count per falling edge", 4, e);
      cnt_pin[1] = 1;
      repeat (3) @(negedge clk);
      tk(2);
      rd("R3 rising edge no count", 4, e);
    end
  endtask

  task automatic t_m13();
    reset_dut();
    wr(0, 8'h00);
    wr(2, 8'h1F); wr(3, 8'h12);
    wr(1, 8'h01);
    tk(1);
    rd("R4 prescaler carry lo", 2, 8'h00);
    rd("R4 prescaler carry hi", 3, 8'h13);
    chk("R4 no flag yet", ovf_flag, 0);
    wr(2, 8'hFE); wr(3, 8'hFF);
    tk(1);
    rd("R4 upper bits kept", 2, 8'hFF);
    tk(1);
    rd("R4 wrap lo", 2, 8'hE0);
    rd("R4 wrap hi", 3, 8'h00);
    chk("R4 flag set", ovf_flag, 2'b01);
  endtask

  task automatic t_m16();
    reset_dut();
    wr(0, 8'h01);
    wr(2, 8'hFE); wr(3, 8'hFF);
    wr(1, 8'h01);
    tk(1);
    chk("R5 no flag at FFFF", ovf_flag, 0);
    tk(1);
    rd("R5 wrap lo", 2, 0);
    rd("R5 wrap hi", 3, 0);
    rd("R5 flag in reg", 1, 8'h05);
  endtask

  task automatic t_reload();
    reset_dut();
    wr(0, 8'h20);
    wr(5, 8'hC0); wr(4, 8'hFE);
    wr(1, 8'h02);
    tk(1);
    rd("R6 before reload", 4, 8'hFF);
    chk("R11 no pulse before", baud_pulse, 0);
    tk(1);
    chk("R11 pulse on overflow", baud_pulse, 1);
    rd("R6 reloaded lo", 4, 8'hC0);
    rd("R6 hi unchanged", 5, 8'hC0);
    chk("R6 flag1 set", ovf_flag, 2'b10);
    @(negedge clk);
    chk("R11 pulse one cycle", baud_pulse, 0);
  endtask

  task automatic t_halt1();
    reset_dut();
    wr(0, 8'h30);
    wr(4, 8'hFF); wr(5, 8'hFF);
    wr(1, 8'h02);
    tk(4);
    rd("R7 halted lo", 4, 8'hFF);
    rd("R7 halted hi", 5, 8'hFF);
    chk("R7 no flag", ovf_flag, 0);
  endtask

  task automatic t_split();
    reset_dut();
    wr(0, 8'h13);
    wr(3, 8'hFF); wr(2, 8'hFE);
    wr(1, 8'h03);
    tk(1);
    rd("R8 hi half wraps", 3, 8'h00);
    chk("R8 hi half sets flag1", ovf_flag, 2'b10);
    tk(1);
    rd("R8 lo half wraps", 2, 8'h00);
    rd("R8 hi half counts", 3, 8'h01);
    rd("R8 flags both", 1, 8'h0F);
    rd("R8 ch1 counts", 4, 8'h02);
    wr(1, 8'h01);
    rd("R9 software clear", 1, 8'h01);
    wr(4, 8'hFF); wr(5, 8'hFF);
    tk(1);
    chk("R11 pulse in split", baud_pulse, 1);
    rd("R8 hi half stops without run1", 3, 8'h01);
    rd("R8 lo half continues", 2, 8'h01);
    rd("R8 ch1 wraps lo", 4, 8'h00);
    rd("R8 ch1 no flag1", 1, 8'h01);
  endtask

  task automatic t_ack();
    reset_dut();
    wr(0, 8'h01);
    wr(2, 8'hFF); wr(3, 8'hFF);
    wr(1, 8'h01);
    tk(1);
    chk("R9 flag before ack", ovf_flag, 2'b01);
    @(negedge clk); ack = 2'b01;
    @(negedge clk); ack = 2'b00;
    chk("R9 ack clears", ovf_flag, 2'b00);
    wr(2, 8'hFF); wr(3, 8'hFF);
    @(negedge clk); tick = 1; ack = 2'b01;
    @(negedge clk); tick = 0; ack = 2'b00;
    chk("R9 set beats ack", ovf_flag, 2'b01);
  endtask

  task automatic t_wprio();
    reset_dut();
    wr(0, 8'h01);
    wr(2, 8'h10);
    wr(1, 8'h01);
    @(negedge clk); tick = 1; wr_en = 1; addr = 2; wdata = 8'h40;
    @(negedge clk); tick = 0; wr_en = 0;
    rd("R10 write wins lo", 2, 8'h40);
    rd("R10 hi untouched", 3, 8'h00);
    tk(1);
    rd("R10 counting resumes", 2, 8'h41);
  endtask

  initial begin
    t_reset();
    t_gate();
    t_ext();
    t_m13();
    t_m16();
    t_reload();
    t_halt1();
    t_split();
    t_ack();
    t_wprio();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule